// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the per-channel control core of a synchronous rectifier. It replaces a diode with a switch, and it decides when that switch turns on and off. It reads four qualified comparator flags:

- a turn-on flag, set when the drain sits well below the source;
- a regulation flag, which requests a weak pull-down;
- a turn-off flag, set when the drain has risen to near zero current;
- a re-arm flag, set when the drain is clearly positive.

From these it produces a three-level gate command. All timing is counted in cycles of one system clock. The turn-on dwell and the re-arm qualification are parameters. The minimum on time is a run-time input.

A conduction cycle runs through four states:

- **BLANKED.** The channel waits here after reset and after every turn-off. It leaves (transition *rearm*) only once the re-arm flag has held for `REARM_DWELL` consecutive cycles, which moves it to **ARMED**.
- **ARMED.** The channel goes to **MIN_ON** (transition *fire*) once the turn-on flag has held for `ON_DWELL` consecutive cycles.
- **MIN_ON.** The gate is driven strong high and every flag is ignored for the programmed minimum on time. At the end of that time the turn-off flag is sampled (transition *expire*):
  - If the flag is set, conduction was shorter than the minimum on time. The channel reports a short cycle and returns straight to BLANKED.
  - Otherwise it goes to **REGULATE**.
- **REGULATE.** The regulation flag switches the gate between weak pull-down and strong high. The turn-off flag ends the cycle (transition *cutoff*) and returns the channel to BLANKED.

A supervisor enable can mask every gate pulse. While it is low, the sequence and the short-cycle report keep running.

Top module: `sr_gate_seq`

## Requirements
- R1: While `rst` is high, and after it is released, the channel is in BLANKED with `gate_cmd` = 00 and `short_cycle` = 0. The turn-on flag cannot fire the gate before a re-arm.
- R2: `gate_cmd` uses 00 = strong low, 01 = weak pull-down, 10 = strong high, and never shows 11.
- R3: In ARMED, `gate_cmd` becomes 10 in the cycle that follows the `ON_DWELL`-th consecutive clock edge at which `on_flag` is sampled high.
- R4: If `on_flag` drops before the dwell completes, the dwell count restarts from zero.
- R5: Once fired, `gate_cmd` stays 10 for exactly max(`mot_len`,1) cycles. `reg_flag`, `off_flag` and `on_flag` have no effect during that window.
- R6: In REGULATE, `gate_cmd` is 01 while `reg_flag` is high and 10 while it is low. The output follows `reg_flag` combinationally.
- R7: In REGULATE, a sampled `off_flag` moves the channel to BLANKED with `gate_cmd` = 00. After that, `on_flag` cannot turn the gate on.
- R8: Leaving BLANKED requires `rearm_flag` high on `REARM_DWELL` consecutive edges. A shorter excursion restarts the qualification.
- R9: If `off_flag` is high at the last edge of the minimum on time, `short_cycle` is 1 for exactly the next cycle and the channel goes directly to BLANKED. Otherwise `short_cycle` stays 0.
- R10: With `en` low, `gate_cmd` is 00, yet state changes, timers and `short_cycle` behave exactly as with `en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Supervisor enable; low masks the gate |
| on_flag | input | 1 | Drain below turn-on threshold |
| reg_flag | input | 1 | Drain below regulation threshold (weak pull-down request) |
| off_flag | input | 1 | Drain above turn-off threshold |
| rearm_flag | input | 1 | Drain above positive re-arm threshold |
| mot_len | input | MOT_W | Minimum on time in clock cycles (0 acts as 1) |
| gate_cmd | output | 2 | Gate command: 00 low, 01 weak pull-down, 10 high |
| short_cycle | output | 1 | One-cycle pulse reporting conduction shorter than the minimum on time |

## Verification
The bench builds the block with `ON_DWELL` = 3, `REARM_DWELL` = 4 and `MOT_W` = 3. With these values every minimum on time from 0 to 7 can be swept in full, and each one is crossed with both short-cycle outcomes and both enable levels. The dwell and re-arm windows are only a few cycles long, so the bench can place an excursion one cycle short of qualification and another that qualifies exactly. It then checks the gate cycle by cycle against counts computed from the requirements.

// File: rtl/srg_pkg.sv
package srg_pkg;

    typedef enum logic [1:0] {
        ST_BLANK  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_MIN_ON = 2'd2,
        ST_REG    = 2'd3
    } srg_state_e;

    localparam logic [1:0] GATE_LOW  = 2'b00;
    localparam logic [1:0] GATE_WEAK = 2'b01;
    localparam logic [1:0] GATE_HIGH = 2'b10;

endpackage

// File: rtl/srg_dwell.sv
module srg_dwell #(
    parameter int LEN = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic watch,
    input  logic lvl,
    output logic done
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);

    logic [CW-1:0] cnt_q;

    assign done = watch && lvl && (cnt_q == CW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !watch || !lvl || done)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4
    dwell_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (!lvl) |=> (cnt_q == '0));
endmodule

// File: rtl/srg_mot_timer.sv
module srg_mot_timer #(
    parameter int MOT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [MOT_W-1:0] mot_len,
    output logic             last
);
    logic [MOT_W-1:0] cnt_q;
    logic [MOT_W:0]   elapsed;

    assign elapsed = {1'b0, cnt_q} + 1'b1;
    assign last    = run && (elapsed >= {1'b0, mot_len});

    always_ff @(posedge clk) begin
        if (rst || !run || last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
    import srg_pkg::*;
#(
    parameter int ON_DWELL    = 15,
    parameter int REARM_DWELL = 40,
    parameter int MOT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             on_flag,
    input  logic             reg_flag,
    input  logic             off_flag,
    input  logic             rearm_flag,
    input  logic [MOT_W-1:0] mot_len,
    output logic [1:0]       gate_cmd,
    output logic             short_cycle
);
    srg_state_e state_q, state_d;
    logic       on_done, rearm_done, mot_last;
    logic       short_q;
    logic [1:0] gate_raw;

    srg_dwell #(.LEN(ON_DWELL)) u_on_dwell (
        .clk(clk), .rst(rst), .watch(state_q == ST_ARMED),
        .lvl(on_flag), .done(on_done)
    );

    srg_dwell #(.LEN(REARM_DWELL)) u_rearm_dwell (
        .clk(clk), .rst(rst), .watch(state_q == ST_BLANK),
        .lvl(rearm_flag), .done(rearm_done)
    );

    srg_mot_timer #(.MOT_W(MOT_W)) u_mot (
        .clk(clk), .rst(rst), .run(state_q == ST_MIN_ON),
        .mot_len(mot_len), .last(mot_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK:  if (rearm_done) state_d = ST_ARMED;
            ST_ARMED:  if (on_done)    state_d = ST_MIN_ON;
            ST_MIN_ON: if (mot_last)   state_d = off_flag ? ST_BLANK : ST_REG;
            ST_REG:    if (off_flag)   state_d = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BLANK;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            short_q <= mot_last && off_flag;
        end
    end

    always_comb begin
        gate_raw = GATE_LOW;
        unique case (state_q)
            ST_BLANK:  gate_raw = GATE_LOW;
            ST_ARMED:  gate_raw = GATE_LOW;
            ST_MIN_ON: gate_raw = GATE_HIGH;
            ST_REG:    gate_raw = reg_flag ? GATE_WEAK : GATE_HIGH;
        endcase
        gate_cmd = en ? gate_raw : GATE_LOW;
    end

    assign short_cycle = short_q;

    // R2
    always_comb begin
        if (!rst) gate_code_chk: assert (gate_cmd != 2'b11);
    end

    // R5
    min_on_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MIN_ON && !mot_last) |=> (state_q == ST_MIN_ON));

    // R3
    fire_from_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MIN_ON && $past(state_q) != ST_MIN_ON)
            |-> ($past(state_q) == ST_ARMED && $past(on_flag)));

    // R7
    cutoff_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REG && off_flag) |=> (state_q == ST_BLANK));

    // R8
    blank_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BLANK && !rearm_flag) |=> (state_q == ST_BLANK));

    // R9
    short_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        short_cycle |-> (state_q == ST_BLANK) ##1 !short_cycle);

    // R10
    mask_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> (gate_cmd == GATE_LOW));
endmodule

// File: tb/sr_gate_seq_bench.sv
module sr_gate_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ON_C  = 3;
    localparam int RA_C  = 4;
    localparam int MW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b1;
    logic          on_flag = 1'b0, reg_flag = 1'b0, off_flag = 1'b0, rearm_flag = 1'b0;
    logic [MW-1:0] mot_len = '0;
    logic [1:0]    gate_cmd;
    logic          short_cycle;

    int n_vec  = 0;
    int n_fail = 0;

    sr_gate_seq #(.ON_DWELL(ON_C), .REARM_DWELL(RA_C), .MOT_W(MW)) u_sr_gate_seq (
        .clk(clk), .rst(rst), .en(en), .on_flag(on_flag), .reg_flag(reg_flag),
        .off_flag(off_flag), .rearm_flag(rearm_flag), .mot_len(mot_len),
        .gate_cmd(gate_cmd), .short_cycle(short_cycle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int gexp(input int code);
        return en ? code : 0;
    endfunction

    task automatic arm();
        on_flag = 0; reg_flag = 0; off_flag = 0;
        rearm_flag = 1;
        repeat (RA_C) tick();
        rearm_flag = 0;
    endtask

    // One full conduction cycle from ARMED, with arithmetic expectations
    task automatic pulse(input int m, input bit shrt);
        int meff;
        meff = (m == 0) ? 1 : m;
        mot_len = MW'(m);
        on_flag = 1; reg_flag = 1; off_flag = shrt;
        for (int k = 1; k < ON_C + meff; k++) begin
            tick();
            if (k < ON_C) chk("R3 dwell", gate_cmd, 0);
            else          chk("R5 min on", gate_cmd, gexp(2));
        end
        tick();
        if (shrt) begin
            chk("R9 short gate", gate_cmd, 0);
            chk("R9 short flag", short_cycle, 1);
            off_flag = 0;
            tick();
            chk("R9 one cycle", short_cycle, 0);
            repeat (2) begin
                tick();
                chk("R9 blanked", gate_cmd, 0);
            end
        end else begin
            chk("R6 weak", gate_cmd, gexp(1));
            chk("R9 no short", short_cycle, 0);
            reg_flag = 0;
            #1;
            chk("R6 high", gate_cmd, gexp(2));
            off_flag = 1; on_flag = 0;
            tick();
            chk("R7 cutoff", gate_cmd, 0);
            on_flag = 1; reg_flag = 1; off_flag = 0;
            repeat (ON_C + 1) begin
                tick();
                chk("R7 blanked", gate_cmd, 0);
            end
        end
        on_flag = 0; reg_flag = 0; off_flag = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        mot_len = MW'(2);
        repeat (3) tick();
        chk("R1 reset gate", gate_cmd, 0);
        chk("R1 reset short", short_cycle, 0);
        rst = 0;
        on_flag = 1;
        repeat (ON_C + 2) begin
            tick();
            chk("R1 unarmed", gate_cmd, 0);
        end
        on_flag = 0;

        // R8: excursions one short of qualification
        repeat (2) begin
            rearm_flag = 1;
            repeat (RA_C - 1) tick();
            rearm_flag = 0;
            tick();
        end
        on_flag = 1;
        repeat (ON_C + 2) begin
            tick();
            chk("R8 not armed", gate_cmd, 0);
        end
        on_flag = 0;

        // R4: broken dwell restarts, then R3 exact dwell
        arm();
        on_flag = 1;
        repeat (ON_C - 1) begin
            tick();
            chk("R4 partial", gate_cmd, 0);
        end
        on_flag = 0;
        tick();
        chk("R4 gap", gate_cmd, 0);
        on_flag = 1;
        repeat (ON_C - 1) begin
            tick();
            chk("R4 restarted", gate_cmd, 0);
        end
        tick();
        chk("R3 fire", gate_cmd, 2);
        on_flag = 0; off_flag = 1;
        repeat (4) tick();
        off_flag = 0;

        for (int e = 0; e < 2; e++) begin
            en = (e == 0);
            for (int m = 0; m < (1 << MW); m++) begin
                for (int s = 0; s < 2; s++) begin
                    arm();
                    pulse(m, s[0]);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule